// File: doc/BRIEF.md
# Masked-Address GPIO Register Port

An eight-pin general-purpose I/O port behind a 32-bit register interface. A direction register sets each pin to input or output. Output pins drive their data bit. Input pins present a constant high on their output level, and their data bit follows the synchronized external level. On any access to the data window, address bits [9:2] act as a per-bit mask. Software can therefore set or clear single pins in one write, or read a chosen subset in one read, with no read-modify-write.

An alternate-function select register is guarded by a commit mask. The commit mask itself can only change while a key-controlled lock is open. The lock is a two-state machine:
- `LK_LOCKED` is the reset state. A key write moves it to `LK_OPEN`. Any other write to the lock register leaves it in `LK_LOCKED`.
- In `LK_OPEN`, a key write keeps it in `LK_OPEN`. Any other write to the lock register moves it back to `LK_LOCKED`.

Nine pad-configuration bytes are stored and read back only. Twelve identification bytes are read-only. Interrupt detection belongs to a neighbouring block.

Top module: `gpio_mask_port`

## Requirements
- R1: A read at any byte offset below 0x400 returns the data register ANDed with address bits [9:2], zero-extended to 32 bits.
- R2: A write at any byte offset below 0x400 changes only those data bits whose address-mask bit and direction bit are both 1. It writes them from wdata[7:0]; every other data bit keeps its value.
- R3: The direction register sits at 0x400 and stores wdata[7:0]. A 1 means output. It resets to 0x00.
- R4: pin_out[i] equals data bit i when pin i is an output, and 1 when pin i is an input. The value updates in the cycle after the write edge.
- R5: pin_in passes two synchronizer flops. A change that is set up before edge E1 reaches the data bit of an input pin at edge E3. Output pins ignore pin_in.
- R6: A write of 0x0ACCE551 to 0x520 opens the lock; any other value there closes it. The lock resets closed, and a read of 0x520 returns 1 when closed and 0 when open.
- R7: The commit mask at 0x524 resets to 0xFF and takes wdata[7:0] only while the lock is open.
- R8: The alternate-function register at 0x420 resets to 0x00. A write there changes only the bits set in the commit mask.
- R9: The pad bytes sit at 0x500, 0x504, 0x508, 0x50C, 0x510, 0x514, 0x518, 0x51C and 0x528, and each stores 8 bits. The byte at 0x500 resets to 0xFF; the others reset to 0x00.
- R10: Offsets 0xFD0 to 0xFFC, one word each, read as 0x00,0x00,0x00,0x00,0x61,0x10,0x04,0x00,0x0D,0xF0,0x05,0xB1 in increasing address order.
- R11: Reads of any other offset return 0, and writes to them change no register.
- R12: rdata loads on the edge where rd_en is 1 and holds its value while rd_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 12 | Byte address; bits [1:0] ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Asynchronous external pin levels |
| pin_out | output | 8 | Per-pin output levels |

## Verification
Each result has its own latency:
- A read result is due one edge after rd_en, so the bench compares rdata at the following falling edge.
- A register write shows on pin_out in that same window.
- An input change needs three rising edges to reach the data register. The bench reads at the third edge to see the old value, and at the fourth to see the new one.

During random runs, every change to pin_in is followed by idle cycles before the next read. This keeps the bench model in step with the synchronizer.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
    localparam int unsigned PINS   = 8;
    localparam int unsigned AW     = 12;
    localparam int unsigned DW     = 32;
    localparam int unsigned WW     = AW - 2;
    localparam int unsigned PAD_N  = 9;
    localparam int unsigned ID_N   = 12;

    localparam logic [WW-1:0] W_DIR    = 10'h100;
    localparam logic [WW-1:0] W_AFSEL  = 10'h108;
    localparam logic [WW-1:0] W_PAD0   = 10'h140;
    localparam logic [WW-1:0] W_LOCK   = 10'h148;
    localparam logic [WW-1:0] W_COMMIT = 10'h149;
    localparam logic [WW-1:0] W_PAD8   = 10'h14A;
    localparam logic [WW-1:0] W_ID0    = 10'h3F4;

    localparam logic [DW-1:0] UNLOCK_KEY = 32'h0ACC_E551;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;

    function automatic logic [3:0] pad_slot(input logic [WW-1:0] w);
        if (w >= W_PAD0 && w < W_LOCK)
            pad_slot = 4'(w - W_PAD0);
        else if (w == W_PAD8)
            pad_slot = 4'(PAD_N - 1);
        else
            pad_slot = 4'hF;
    endfunction

    function automatic logic [7:0] id_byte(input logic [3:0] k);
        case (k)
            4'd4:    id_byte = 8'h61;
            4'd5:    id_byte = 8'h10;
            4'd6:    id_byte = 8'h04;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1_q[g] <= 1'b0;
                sync_out[g] <= 1'b0;
            end else begin
                stage1_q[g] <= async_in[g];
                sync_out[g] <= stage1_q[g];
            end
        end
    end
endmodule

// File: rtl/gpio_pin_data.sv
module gpio_pin_data #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_we,
    input  logic             data_we,
    input  logic [WIDTH-1:0] data_mask,
    input  logic [WIDTH-1:0] wbyte,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] pin_out
);
    logic [WIDTH-1:0] data_nxt;

    always_comb begin
        for (int i = 0; i < int'(WIDTH); i++) begin
            if (!dir_q[i])
                data_nxt[i] = pin_sync[i];
            else if (data_we && data_mask[i])
                data_nxt[i] = wbyte[i];
            else
                data_nxt[i] = data_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            data_q <= '0;
        end else begin
            data_q <= data_nxt;
            if (dir_we)
                dir_q <= wbyte;
        end
    end

    assign pin_out = (data_q & dir_q) | ~dir_q;
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_mask_pkg::*;
#(
    parameter int unsigned NPAD = PAD_N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock_we,
    input  logic                 commit_we,
    input  logic                 afsel_we,
    input  logic                 pad_we,
    input  logic [3:0]           pad_sel,
    input  logic [DW-1:0]        wdata,
    output logic                 lock_open,
    output logic [7:0]           commit_q,
    output logic [7:0]           afsel_q,
    output logic [NPAD-1:0][7:0] pad_q
);
    lock_state_e state_q, state_nxt;
    logic        key_hit;

    assign key_hit = (wdata == UNLOCK_KEY);

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= LK_LOCKED;
        else
            state_q <= state_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        if (lock_we) begin
            unique case (state_q)
                LK_LOCKED: state_nxt = key_hit ? LK_OPEN : LK_LOCKED;
                LK_OPEN:   state_nxt = key_hit ? LK_OPEN : LK_LOCKED;
            endcase
        end
    end

    always_comb begin
        lock_open = (state_q == LK_OPEN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= 8'hFF;
            afsel_q  <= 8'h00;
        end else begin
            if (commit_we && lock_open)
                commit_q <= wdata[7:0];
            if (afsel_we)
                afsel_q <= (afsel_q & ~commit_q) | (wdata[7:0] & commit_q);
        end
    end

    for (genvar g = 0; g < NPAD; g++) begin : g_pad
        localparam logic [7:0] RST_VAL = (g == 0) ? 8'hFF : 8'h00;
        always_ff @(posedge clk) begin
            if (!rst_n)
                pad_q[g] <= RST_VAL;
            else if (pad_we && pad_sel == 4'(g))
                pad_q[g] <= wdata[7:0];
        end
    end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [11:0]   bus_addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic [7:0]    pin_in,
    output logic [7:0]    pin_out
);
    logic [WW-1:0]          word;
    logic                   in_data_win;
    logic [PINS-1:0]        addr_mask;
    logic [3:0]             slot;
    logic [WW-1:0]          id_off;
    logic [PINS-1:0]        pin_sync;
    logic [PINS-1:0]        dir_q;
    logic [PINS-1:0]        data_q;
    logic [7:0]             commit_q;
    logic [7:0]             afsel_q;
    logic [PAD_N-1:0][7:0]  pad_q;
    logic                   lock_open;
    logic [DW-1:0]          rd_mux;
    logic                   unused_bits;

    assign word        = bus_addr[AW-1:2];
    assign in_data_win = (bus_addr[AW-1:10] == '0);
    assign addr_mask   = bus_addr[9:2];
    assign slot        = pad_slot(word);
    assign id_off      = word - W_ID0;
    assign unused_bits = ^{bus_addr[1:0], id_off[WW-1:4]};

    gpio_in_sync #(.WIDTH(PINS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_pin_data #(.WIDTH(PINS)) pins_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_we    (wr_en && word == W_DIR),
        .data_we   (wr_en && in_data_win),
        .data_mask (addr_mask),
        .wbyte     (wdata[7:0]),
        .pin_sync  (pin_sync),
        .dir_q     (dir_q),
        .data_q    (data_q),
        .pin_out   (pin_out)
    );

    gpio_cfg_bank #(.NPAD(PAD_N)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_we   (wr_en && word == W_LOCK),
        .commit_we (wr_en && word == W_COMMIT),
        .afsel_we  (wr_en && word == W_AFSEL),
        .pad_we    (wr_en && slot != 4'hF),
        .pad_sel   (slot),
        .wdata     (wdata),
        .lock_open (lock_open),
        .commit_q  (commit_q),
        .afsel_q   (afsel_q),
        .pad_q     (pad_q)
    );

    always_comb begin
        rd_mux = '0;
        if (in_data_win)
            rd_mux = {24'h0, data_q & addr_mask};
        else if (word == W_DIR)
            rd_mux = {24'h0, dir_q};
        else if (word == W_AFSEL)
            rd_mux = {24'h0, afsel_q};
        else if (word == W_LOCK)
            rd_mux = {31'h0, !lock_open};
        else if (word == W_COMMIT)
            rd_mux = {24'h0, commit_q};
        else if (slot < 4'(PAD_N))
            rd_mux = {24'h0, pad_q[slot]};
        else if (word >= W_ID0)
            rd_mux = {24'h0, id_byte(id_off[3:0])};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [11:0] bus_addr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic [7:0]  pin_out,
    input logic [7:0]  dir_q,
    input logic [7:0]  data_q,
    input logic [7:0]  commit_q,
    input logic [7:0]  afsel_q,
    input logic        lock_open
);
    logic [7:0] wmask_c;
    logic       lock_wr;
    assign wmask_c = (wr_en && bus_addr[11:10] == 2'b00) ? bus_addr[9:2] : 8'h00;
    assign lock_wr = wr_en && (bus_addr[11:2] == 10'h148);

    // R2
    data_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(wmask_c)) == 8'h00));

    // R4
    input_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_q & ~pin_out) == 8'h00));

    // R6
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && wdata == 32'h0ACCE551) |=> lock_open);

    // R6
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && wdata != 32'h0ACCE551) |=> !lock_open);

    // R7
    commit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_open |=> $stable(commit_q));

    // R8
    afsel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((afsel_q ^ $past(afsel_q)) & ~$past(commit_q)) == 8'h00));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind gpio_mask_port gpio_mask_port_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .bus_addr  (bus_addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .pin_out   (pin_out),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .commit_q  (commit_q),
    .afsel_q   (afsel_q),
    .lock_open (lock_open)
);

// File: tb/gpio_mask_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mask_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pin_in = 8'h00;
    logic [7:0]  pin_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] m_data, m_dir, m_commit, m_afsel;
    logic       m_locked;
    logic [7:0] m_pad [9];

    always #2 clk = ~clk;

    gpio_mask_port dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .bus_addr(bus_addr), .wdata(wdata), .rdata(rdata),
        .pin_in(pin_in), .pin_out(pin_out)
    );

    function automatic logic [7:0] tb_id(input int k);
        case (k)
            4: return 8'h61;  5: return 8'h10;  6: return 8'h04;
            8: return 8'h0D;  9: return 8'hF0;  10: return 8'h05;
            11: return 8'hB1; default: return 8'h00;
        endcase
    endfunction

    function automatic int tb_pad(input logic [9:0] w);
        if (w >= 10'h140 && w <= 10'h147) return int'(w - 10'h140);
        if (w == 10'h14A) return 8;
        return -1;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [9:0] w = a[11:2];
        if (a < 12'h400) return {24'h0, m_data & a[9:2]};
        if (w == 10'h100) return {24'h0, m_dir};
        if (w == 10'h108) return {24'h0, m_afsel};
        if (w == 10'h148) return {31'h0, m_locked};
        if (w == 10'h149) return {24'h0, m_commit};
        if (tb_pad(w) >= 0) return {24'h0, m_pad[tb_pad(w)]};
        if (w >= 10'h3F4) return {24'h0, tb_id(int'(w - 10'h3F4))};
        return 32'h0;
    endfunction

    function automatic logic [7:0] exp_pins();
        return (m_data & m_dir) | ~m_dir;
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] v);
        logic [9:0] w = a[11:2];
        logic [7:0] mk;
        if (a < 12'h400) begin
            mk = a[9:2] & m_dir;
            m_data = (m_data & ~mk) | (v[7:0] & mk);
        end else if (w == 10'h100) begin
            m_dir = v[7:0];
            m_data = (m_data & m_dir) | (pin_in & ~m_dir);
        end else if (w == 10'h108) m_afsel = (m_afsel & ~m_commit) | (v[7:0] & m_commit);
        else if (w == 10'h148) m_locked = (v != 32'h0ACCE551);
        else if (w == 10'h149) begin if (!m_locked) m_commit = v[7:0]; end
        else if (tb_pad(w) >= 0) m_pad[tb_pad(w)] = v[7:0];
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; bus_addr = a; wdata = v;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, v);
        @(posedge clk);
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] r);
        @(negedge clk);
        rd_en = 1'b1; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        r = rdata;
    endtask

    task automatic read_chk(input string tag, input logic [11:0] a);
        logic [31:0] r;
        do_read(a, r);
        check(tag, r, exp_read(a));
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (4) @(posedge clk);
        m_data = (m_data & m_dir) | (p & ~m_dir);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired got=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5EED_0042));
        m_data = 0; m_dir = 0; m_commit = 8'hFF; m_afsel = 0; m_locked = 1'b1;
        foreach (m_pad[i]) m_pad[i] = (i == 0) ? 8'hFF : 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // reset state
        check("R4 reset pins", {24'h0, pin_out}, 32'hFF);
        read_chk("R3 reset dir", 12'h400);
        read_chk("R6 reset lock", 12'h520);
        read_chk("R7 reset commit", 12'h524);
        read_chk("R8 reset afsel", 12'h420);
        read_chk("R9 reset pad0", 12'h500);
        read_chk("R9 reset pad8", 12'h528);
        read_chk("R1 reset data", 12'h3FC);

        // direction and masked data writes
        do_write(12'h400, 32'h0000_00F0);
        read_chk("R3 dir", 12'h400);
        do_write(12'h3FC, 32'h0000_00A5);
        check("R4 pins", {24'h0, pin_out}, {24'h0, exp_pins()});
        check("R4 pins literal", {24'h0, pin_out}, 32'hAF);
        do_write(12'h0C0, 32'h0000_0000);
        check("R2 masked clear", {24'h0, pin_out}, 32'h8F);
        do_write(12'h03C, 32'h0000_00FF);
        read_chk("R2 input bits untouched", 12'h3FC);
        read_chk("R1 masked read", 12'h300);
        check("R1 literal", exp_read(12'h300), 32'h80);

        // synchronizer latency boundary
        @(negedge clk); pin_in = 8'h5A;
        @(posedge clk); @(posedge clk);
        do_read(12'h3FC, r);
        check("R5 third edge old", r, 32'h80);
        do_read(12'h3FC, r);
        check("R5 fourth edge new", r, 32'h8A);
        m_data = 8'h8A;
        check("R4 out pins ignore input", {24'h0, pin_out}, 32'h8F);

        // lock, commit and alternate function
        do_write(12'h524, 32'h0F);
        read_chk("R7 commit locked", 12'h524);
        do_write(12'h420, 32'hFF);
        read_chk("R8 afsel full commit", 12'h420);
        do_write(12'h520, 32'h0ACCE551);
        read_chk("R6 unlocked", 12'h520);
        do_write(12'h524, 32'h0F);
        read_chk("R7 commit open", 12'h524);
        do_write(12'h520, 32'h0ACCE550);
        read_chk("R6 relocked", 12'h520);
        do_write(12'h524, 32'h00);
        read_chk("R7 commit ignored", 12'h524);
        do_write(12'h420, 32'h00);
        read_chk("R8 afsel masked", 12'h420);
        check("R8 literal", exp_read(12'h420), 32'hF0);

        // pads and identification
        do_write(12'h514, 32'hDEAD_BE3C);
        read_chk("R9 pad 0x514", 12'h514);
        do_write(12'h528, 32'h77);
        read_chk("R9 pad 0x528", 12'h528);
        for (int k = 0; k < 12; k++) read_chk("R10 id", 12'hFD0 + 12'(4 * k));

        // unmapped offsets
        do_write(12'h404, 32'hFF);
        read_chk("R11 unmapped read", 12'h404);
        do_write(12'h41C, 32'hFF);
        read_chk("R11 dir unaffected", 12'h400);
        read_chk("R11 far hole", 12'h600);

        // read data hold
        do_read(12'h400, r);
        do_write(12'h400, 32'h33);
        check("R12 rdata held", rdata, r);

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [11:0] a;
            logic [31:0] v;
            int sel = $urandom_range(0, 9);
            v = $urandom;
            case (sel)
                0, 1: a = {$urandom_range(0, 255) & 8'hFF, 2'b00} & 12'h3FC;
                2: a = 12'h400;
                3: a = 12'h420;
                4: begin a = 12'h520; if ($urandom_range(0, 1) == 1) v = 32'h0ACCE551; end
                5: a = 12'h524;
                6: a = ($urandom_range(0, 8) == 8) ? 12'h528 : 12'h500 + 12'(4 * $urandom_range(0, 7));
                7: a = 12'hFD0 + 12'(4 * $urandom_range(0, 11));
                8: a = 12'h424 + 12'(4 * $urandom_range(0, 100));
                default: a = 12'h3FC;
            endcase
            if (sel == 9) set_pins(8'($urandom));
            else if ($urandom_range(0, 1) == 1) do_write(a, v);
            read_chk("R1 R3 R6 R7 R8 R9 R10 R11 random", a);
            check("R4 random pins", {24'h0, pin_out}, {24'h0, exp_pins()});
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule